// File: doc/BRIEF.md
# SPI Register Port with Address-Dependent Streaming Reads

This block is an SPI slave in clock mode 0 that connects a host to a simple on-chip register bus. Every transfer opens with a command byte. The top bit of that byte selects read or write, and the low seven bits give the start address. On a write, the bytes that follow go onto the register bus one by one, and the address advances after each byte. On a read, the port streams data out on MISO. How much data it sends depends on the start address. Ordinary registers stream byte after byte with the same address advance. The measurement addresses return one wide snapshot, taken in a single cycle so that all of its bits belong together.

The SPI pins are sampled in the block's own clock domain through two-stage synchronisers. Rising and falling SCK edges are found there. The SPI clock must therefore stay well below the system clock; a half period of at least five system cycles is assumed. One address is claimed locally as an instruction register. Its low five bits act as one-cycle command pulses, and the two bits above them drive two held actuator levels.

Top module: `spi_regport`

## Requirements
- R1: MOSI is sampled on the rising SCK edge, MSB first. MISO changes only after a falling SCK edge, MSB first.
- R2: The first byte of a transfer is a command: bit 7 = 1 means read, bit 7 = 0 means write, and bits 6:0 are the start address.
- R3: In a write, each further complete byte produces exactly one single-cycle `reg_wr` with `reg_wdata` set to that byte. The first byte uses the start address and each following byte uses the next address.
- R4: A read of any address other than 0x08, 0x0A, 0x0C or 0x0E returns `reg_rdata` one byte at a time. The first data bit is presented after the first falling SCK edge that follows the command. `reg_rd` pulses once per byte at increasing addresses. The next byte is fetched as the last bit of the current byte is shifted out.
- R5: A read of 0x0A, 0x0C or 0x0E returns bits 25:0 of `wide_data` as 26 bits, MSB first. These bits are captured together with a single `reg_rd` when the command completes. Changes to `wide_data` after that do not affect the stream, and the bits after the 26th are 0.
- R6: A read of 0x08 returns bits CNT_W+1:0 of `wide_data` (counter value followed by two status bits), that is CNT_W+2 bits with a single `reg_rd`.
- R7: A rising edge on `spi_cs_n` aborts the transfer. An unfinished byte causes no bus access, and the next transfer starts again with a command byte.
- R8: `spi_miso_oe` is 1 only while the port is selected, so that MISO is high-impedance while `spi_cs_n` is high.
- R9: A write to address 0x30 never reaches the register bus. Bits 4:0 of the byte appear on `inst_pulse` for exactly one cycle. Bit 5 sets `act[0]` and bit 6 sets `act[1]`, and both hold their value until the next write to 0x30.
- R10: After reset `act` is 0, no strobe or pulse is active, and `spi_miso_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | MISO driver enable |
| reg_addr | output | 7 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_wr | output | 1 | Register bus write strobe |
| reg_rd | output | 1 | Register bus read strobe, one per byte or snapshot |
| reg_rdata | input | 8 | Byte read data, combinational in `reg_addr` |
| wide_data | input | max(CNT_W,24)+2 | Measurement word, combinational in `reg_addr`, LSB aligned |
| act | output | 2 | Held actuator levels |
| inst_pulse | output | 5 | Self-clearing instruction pulses |

## Verification
The assertions assume that SCK is idle low whenever chip select falls. They also assume that each SCK half period is longer than the synchroniser delay plus one cycle, so that a pending fetch or write always completes before the next edge. `reg_rdata` and `wide_data` are taken to follow `reg_addr` in the same cycle. The bench drives SCK with a 50 ns half period, changes MOSI and chip select only while SCK is low, and gives the bus model a purely combinational read path.

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int CNT_W = 24,
  parameter logic [6:0] INST_ADDR = 7'h30,
  localparam int WIDE_W = ((CNT_W > 24) ? CNT_W : 24) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic [6:0]        reg_addr,
  output logic [7:0]        reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [7:0]        reg_rdata,
  input  logic [WIDE_W-1:0] wide_data,
  output logic [1:0]        act,
  output logic [4:0]        inst_pulse
);
  localparam int OW = $clog2(WIDE_W + 1);
  localparam int SH_CNT = WIDE_W - (CNT_W + 2);
  localparam int SH_MEAS = WIDE_W - 26;
  localparam logic [OW-1:0] LEN_CNT = OW'(CNT_W + 2);
  localparam logic [OW-1:0] LEN_MEAS = OW'(26);
  localparam logic [OW-1:0] LEN_BYTE = OW'(8);

  logic [2:0] sck_s, cs_s;
  logic [1:0] mosi_s;
  logic       sel, rise, fall, mosi_b;

  logic [2:0]        bit_cnt;
  logic              have_cmd, is_rd, wide_mode;
  logic              load_pend, wr_pend, miso_q;
  logic [6:0]        addr, in_sh;
  logic [7:0]        wr_byte;
  logic [WIDE_W-1:0] out_sh;
  logic [OW-1:0]     out_left;
  logic [7:0]        byte_now;
  logic              addr_cnt, addr_meas;

  assign sel    = ~cs_s[1];
  assign rise   = sel & sck_s[1] & ~sck_s[2];
  assign fall   = sel & ~sck_s[1] & sck_s[2];
  assign mosi_b = mosi_s[1];
  assign byte_now = {in_sh, mosi_b};

  assign addr_cnt  = (addr == 7'h08);
  assign addr_meas = (addr == 7'h0A) | (addr == 7'h0C) | (addr == 7'h0E);

  assign reg_addr    = addr;
  assign reg_wdata   = wr_byte;
  assign reg_wr      = wr_pend & (addr != INST_ADDR);
  assign reg_rd      = load_pend;
  assign inst_pulse  = (wr_pend && addr == INST_ADDR) ? wr_byte[4:0] : 5'd0;
  assign spi_miso    = miso_q;
  assign spi_miso_oe = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s  <= 3'b000;
      cs_s   <= 3'b111;
      mosi_s <= 2'b00;
    end else begin
      sck_s  <= {sck_s[1:0], spi_sck};
      cs_s   <= {cs_s[1:0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      have_cmd  <= 1'b0;
      is_rd     <= 1'b0;
      wide_mode <= 1'b0;
      load_pend <= 1'b0;
      wr_pend   <= 1'b0;
      miso_q    <= 1'b0;
      addr      <= '0;
      in_sh     <= '0;
      wr_byte   <= '0;
      out_sh    <= '0;
      out_left  <= '0;
      act       <= 2'b00;
    end else begin
      if (wr_pend) begin
        wr_pend <= 1'b0;
        if (addr == INST_ADDR) act <= wr_byte[6:5];
        addr <= addr + 7'd1;
      end
      if (load_pend) begin
        load_pend <= 1'b0;
        if (addr_cnt) begin
          out_sh    <= wide_data << SH_CNT;
          out_left  <= LEN_CNT;
          wide_mode <= 1'b1;
        end else if (addr_meas) begin
          out_sh    <= wide_data << SH_MEAS;
          out_left  <= LEN_MEAS;
          wide_mode <= 1'b1;
        end else begin
          out_sh    <= {reg_rdata, {(WIDE_W-8){1'b0}}};
          out_left  <= LEN_BYTE;
          wide_mode <= 1'b0;
          addr      <= addr + 7'd1;
        end
      end
      if (!sel) begin
        bit_cnt   <= '0;
        have_cmd  <= 1'b0;
        is_rd     <= 1'b0;
        wide_mode <= 1'b0;
        load_pend <= 1'b0;
        miso_q    <= 1'b0;
        out_left  <= '0;
      end else if (rise) begin
        in_sh   <= byte_now[6:0];
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (!have_cmd) begin
            have_cmd  <= 1'b1;
            is_rd     <= byte_now[7];
            addr      <= byte_now[6:0];
            load_pend <= byte_now[7];
          end else if (!is_rd) begin
            wr_pend <= 1'b1;
            wr_byte <= byte_now;
          end
        end
      end else if (fall && have_cmd && is_rd) begin
        if (out_left != '0) begin
          miso_q   <= out_sh[WIDE_W-1];
          out_sh   <= out_sh << 1;
          out_left <= out_left - 1'b1;
          if (out_left == OW'(1) && !wide_mode) load_pend <= 1'b1;
        end else begin
          miso_q <= 1'b0;
        end
      end
    end
  end

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R4
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  // R9
  inst_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_pulse != 5'd0) |=> (inst_pulse == 5'd0));

  // R2
  no_write_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (have_cmd && !is_rd));

  // R7
  deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s[1]) |=> (bit_cnt == 3'd0 && !have_cmd && !spi_miso));

  // R1
  out_on_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !fall && !load_pend) |=> $stable(spi_miso));
endmodule

// File: tb/tb_spi_regport.sv
module tb_spi_regport;
  localparam int CW = 32;
  localparam int WW = 34;

  typedef struct packed {
    logic       wr;
    logic [6:0] a;
    logic [7:0] d;
  } bus_ev_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe, reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [WW-1:0] wide_data, meas_base;
  logic [1:0] act;
  logic [4:0] inst_pulse;

  int checks = 0, errors = 0;
  bit done = 0, oe_seen;
  bus_ev_t exp_q[$];
  logic [4:0] pulse_acc = '0;
  int pulse_cycles = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] rdfn(logic [6:0] a);
    return {1'b0, a} * 8'd3 + 8'd5;
  endfunction

  assign reg_rdata = rdfn(reg_addr);
  assign wide_data = meas_base ^ {27'd0, reg_addr};

  spi_regport #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .wide_data(wide_data),
    .act(act), .inst_pulse(inst_pulse));

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic push(input logic wr, input logic [6:0] a, input logic [7:0] d);
    bus_ev_t e;
    e.wr = wr; e.a = a; e.d = d;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && (reg_wr || reg_rd)) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R4/R7 unexpected bus strobe", {reg_wr, reg_addr, reg_wdata}, 64'd0);
      end else begin
        bus_ev_t e;
        e = exp_q.pop_front();
        check(e.wr == reg_wr && e.a == reg_addr && (!e.wr || e.d == reg_wdata),
              e.wr ? "R3 write event" : "R4/R5/R6 read event",
              {reg_wr, reg_addr, reg_wdata}, {e.wr, e.a, e.d});
      end
    end
    if (inst_pulse != 5'd0) begin
      pulse_acc |= inst_pulse;
      pulse_cycles++;
    end
  end

  task automatic spi_xfer(input logic [63:0] tx, input int n, output logic [63:0] rx);
    @(negedge clk);
    spi_cs_n = 1'b0;
    oe_seen = 1'b1;
    #50;
    rx = '0;
    for (int i = 0; i < n; i++) begin
      spi_mosi = tx[n-1-i];
      #50;
      rx = {rx[62:0], spi_miso};
      oe_seen &= spi_miso_oe;
      spi_sck = 1'b1;
      #50;
      spi_sck = 1'b0;
    end
    #50;
    spi_cs_n = 1'b1;
    spi_mosi = 1'b0;
    #100;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] rx;
    logic [WW-1:0] snap;
    meas_base = 34'h2_5A3C_9E17;
    #35 rst_n = 1'b1;
    #20;
    // R10 reset state
    check(act == 2'b00, "R10 act", act, 0);
    check(spi_miso_oe == 1'b0, "R10/R8 oe idle", spi_miso_oe, 0);
    check(!reg_wr && !reg_rd && inst_pulse == 0, "R10 strobes", {reg_wr, reg_rd, inst_pulse}, 0);

    // R2 R3 R1: write three bytes from 0x05
    push(1, 7'h05, 8'hAA); push(1, 7'h06, 8'h55); push(1, 7'h07, 8'hC3);
    spi_xfer({8'h05, 8'hAA, 8'h55, 8'hC3}, 32, rx);
    check(exp_q.size() == 0, "R3 all writes seen", exp_q.size(), 0);
    check(oe_seen, "R8 oe while selected", oe_seen, 1);
    check(spi_miso_oe == 1'b0, "R8 oe after deselect", spi_miso_oe, 0);

    // R4: plain read of two bytes from 0x40, third byte prefetched
    push(0, 7'h40, 0); push(0, 7'h41, 0); push(0, 7'h42, 0);
    spi_xfer({8'hC0, 16'h0000}, 24, rx);
    check(rx[15:0] == {rdfn(7'h40), rdfn(7'h41)}, "R4 plain read data", rx[15:0], {rdfn(7'h40), rdfn(7'h41)});
    check(exp_q.size() == 0, "R4 read strobes", exp_q.size(), 0);

    // R5: 0x0C snapshot with a change mid-stream, then trailing zeros
    push(0, 7'h0C, 0);
    snap = meas_base ^ 34'h0C;
    fork
      spi_xfer({8'h8C, 34'd0}, 42, rx);
      begin #1500 meas_base = 34'h1_0F0F_F0F0; end
    join
    check(rx[33:8] == snap[25:0], "R5 snapshot coherent", rx[33:8], snap[25:0]);
    check(rx[7:0] == 8'h00, "R5 zeros after data", rx[7:0], 0);
    check(exp_q.size() == 0, "R5 single strobe", exp_q.size(), 0);

    // R6: 0x08 returns CNT_W+2 bits
    push(0, 7'h08, 0);
    snap = meas_base ^ 34'h08;
    spi_xfer({8'h88, 34'd0}, 42, rx);
    check(rx[33:0] == snap, "R6 counter width read", rx[33:0], snap);
    check(exp_q.size() == 0, "R6 single strobe", exp_q.size(), 0);

    // R7: aborted write, then a fresh transfer
    spi_xfer({8'h05, 5'b10110}, 13, rx);
    check(exp_q.size() == 0, "R7 no write on abort", exp_q.size(), 0);
    push(1, 7'h10, 8'h12);
    spi_xfer({8'h10, 8'h12}, 16, rx);
    check(exp_q.size() == 0, "R7 fresh command", exp_q.size(), 0);

    // R9: instruction byte
    pulse_acc = '0; pulse_cycles = 0;
    spi_xfer({8'h30, 8'h75}, 16, rx);
    check(act == 2'b11, "R9 act set", act, 2'b11);
    check(pulse_acc == 5'b10101, "R9 pulse bits", pulse_acc, 5'b10101);
    check(pulse_cycles == 1, "R9 pulse one cycle", pulse_cycles, 1);
    pulse_acc = '0; pulse_cycles = 0;
    spi_xfer({8'h30, 8'h20}, 16, rx);
    check(act == 2'b01, "R9 act held per bit", act, 2'b01);
    check(pulse_cycles == 0, "R9 no pulse for zero bits", pulse_cycles, 0);
    check(exp_q.size() == 0, "R9 nothing on bus", exp_q.size(), 0);

    #200;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule